// File: doc/BRIEF.md
# Fractional-N Feedback Divide Sequencer

This block feeds the feedback divider of a fractional-N frequency synthesizer with a new integer divide value on every reference clock. Two 16-bit frequency words are held in byte-wide registers: a "low tone" word and a "high tone" word. Each word encodes a divide ratio as an unsigned fixed-point number with 4 integer bits and 12 fractional bits. The integer field omits a fixed offset of 16, and the block adds that offset back in hardware.

The block picks one word per cycle. In frequency-shift mode the transmit data bit chooses the word. In amplitude mode the low-tone word is always used. The 12-bit fraction of the chosen word is added into a first-order phase accumulator. The accumulator's carry-out raises the integer divide value by one for that cycle, so the long-run average divide ratio equals the programmed fixed-point value. A change of word, whether from a register write or from the data bit, does not clear the accumulator.

Top module: `frac_div_ctrl`

## Requirements
- R1: While reset is low and on the first clock after it, `div_ratio` is 16, both words read as 0 and the accumulator is 0.
- R2: A byte write on `wr_en` lands at the clock edge. Address 0 is the low-tone word bits 15:8, address 1 is its bits 7:0, address 2 is the high-tone word bits 15:8 and address 3 is its bits 7:0. The other byte of a word keeps its value.
- R3: `div_ratio` equals the selected word's bits 15:12, plus 16, plus the accumulator carry. It is registered and appears one clock after the cycle in which the word was selected.
- R4: Each clock, the 12-bit accumulator adds the selected word's bits 11:0 modulo 4096. A carry is produced when the unwrapped sum is 4096 or more.
- R5: With `fsk_mode` = 1, `tx_bit` = 1 selects the high-tone word and `tx_bit` = 0 selects the low-tone word.
- R6: With `fsk_mode` = 0, the low-tone word is used whatever `tx_bit` is.
- R7: A word change, from a write or from toggling `tx_bit`, keeps the accumulator value. The next addition continues from the current phase.
- R8: Over any 4096 consecutive outputs for one constant word, the sum of `div_ratio` equals 4096 × (bits 15:12 + 16) + bits 11:0.
- R9: A selected word whose fraction is 0 gives a constant `div_ratio` with no carries, as long as the accumulator is at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one divide value per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte slot (see R2) |
| wr_data | input | 8 | Byte to write |
| fsk_mode | input | 1 | 1 = frequency-shift mode, 0 = amplitude mode |
| tx_bit | input | 1 | Transmit data bit, selects the tone in frequency-shift mode |
| div_ratio | output | 6 | Integer divide value for the current reference cycle |

## Verification
Two functions can act in the same cycle: a byte write into the word currently in use, and a tone switch by `tx_bit` while the accumulator is about to carry. The bench provokes both by rewriting single bytes and toggling the data bit while a large fraction keeps the accumulator carrying often. Each clock, a behavioural model that takes the old word for the current addition and the new byte only afterwards judges every divide value. A 4096-cycle sum then confirms that the average ratio equals the programmed value.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
    localparam int FDC_WORD_W = 16;
    localparam int FDC_FRAC_W = 12;
    localparam int FDC_BYTE_W = 8;
    localparam int FDC_OFFSET = 16;

    // Byte slot order: the more significant byte sits at the lower address.
    typedef enum logic [1:0] {
        SLOT_LOW_TONE_HI  = 2'd0,
        SLOT_LOW_TONE_LO  = 2'd1,
        SLOT_HIGH_TONE_HI = 2'd2,
        SLOT_HIGH_TONE_LO = 2'd3
    } fdc_slot_e;
endpackage

// File: rtl/fdc_word_regs.sv
module fdc_word_regs #(
    parameter int WORD_W = fdc_pkg::FDC_WORD_W,
    parameter int BYTE_W = fdc_pkg::FDC_BYTE_W,
    localparam int NBYTES = WORD_W / BYTE_W,
    localparam int ADDR_W = $clog2(2 * NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [WORD_W-1:0] lo_word,
    output logic [WORD_W-1:0] up_word
);
    typedef struct packed {
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] up;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                // byte index 0 is the most significant byte
                if (int'(wr_addr) == b)
                    st_d.lo[(NBYTES-1-b)*BYTE_W +: BYTE_W] = wr_data;
                if (int'(wr_addr) == NBYTES + b)
                    st_d.up[(NBYTES-1-b)*BYTE_W +: BYTE_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_word = st_q.lo;
    assign up_word = st_q.up;
endmodule

// File: rtl/fdc_word_sel.sv
module fdc_word_sel #(
    parameter int WORD_W = fdc_pkg::FDC_WORD_W
) (
    input  logic              fsk_mode,
    input  logic              tx_bit,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] up_word,
    output logic [WORD_W-1:0] sel_word
);
    always_comb begin
        if (fsk_mode && tx_bit) sel_word = up_word;
        else                    sel_word = lo_word;
    end
endmodule

// File: rtl/fdc_phase_accum.sv
module fdc_phase_accum #(
    parameter int WORD_W = fdc_pkg::FDC_WORD_W,
    parameter int FRAC_W = fdc_pkg::FDC_FRAC_W,
    parameter int OFFSET = fdc_pkg::FDC_OFFSET,
    localparam int INT_W = WORD_W - FRAC_W,
    localparam int DIV_W = $clog2((1 << INT_W) + OFFSET + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] sel_word,
    output logic [FRAC_W-1:0] acc_phase,
    output logic [DIV_W-1:0]  div_out
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc;
        logic [DIV_W-1:0]  div;
    } acc_t;

    acc_t st_d, st_q;
    logic [FRAC_W:0]  sum_w;
    logic [INT_W-1:0] int_part;

    always_comb begin
        int_part = sel_word[WORD_W-1:FRAC_W];
        sum_w    = {1'b0, st_q.acc} + {1'b0, sel_word[FRAC_W-1:0]};
        st_d.acc = sum_w[FRAC_W-1:0];
        st_d.div = DIV_W'(int_part) + DIV_W'(OFFSET) + DIV_W'(sum_w[FRAC_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc <= '0;
            st_q.div <= DIV_W'(OFFSET);
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_phase = st_q.acc;
    assign div_out   = st_q.div;
endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl #(
    parameter int WORD_W = fdc_pkg::FDC_WORD_W,
    parameter int FRAC_W = fdc_pkg::FDC_FRAC_W,
    parameter int BYTE_W = fdc_pkg::FDC_BYTE_W,
    parameter int OFFSET = fdc_pkg::FDC_OFFSET,
    localparam int INT_W  = WORD_W - FRAC_W,
    localparam int NBYTES = WORD_W / BYTE_W,
    localparam int ADDR_W = $clog2(2 * NBYTES),
    localparam int DIV_W  = $clog2((1 << INT_W) + OFFSET + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              fsk_mode,
    input  logic              tx_bit,
    output logic [DIV_W-1:0]  div_ratio
);
    logic [WORD_W-1:0] lo_word;
    logic [WORD_W-1:0] up_word;
    logic [WORD_W-1:0] sel_word;
    logic [FRAC_W-1:0] acc_phase;

    fdc_word_regs #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lo_word (lo_word),
        .up_word (up_word)
    );

    fdc_word_sel #(.WORD_W(WORD_W)) i_sel (
        .fsk_mode (fsk_mode),
        .tx_bit   (tx_bit),
        .lo_word  (lo_word),
        .up_word  (up_word),
        .sel_word (sel_word)
    );

    fdc_phase_accum #(.WORD_W(WORD_W), .FRAC_W(FRAC_W), .OFFSET(OFFSET)) i_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_word  (sel_word),
        .acc_phase (acc_phase),
        .div_out   (div_ratio)
    );
endmodule

// File: rtl/frac_div_ctrl_chk.sv
module frac_div_ctrl_chk #(
    parameter int WORD_W = 16,
    parameter int FRAC_W = 12,
    parameter int OFFSET = 16,
    parameter int DIV_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fsk_mode,
    input logic              tx_bit,
    input logic [WORD_W-1:0] lo_word,
    input logic [WORD_W-1:0] up_word,
    input logic [WORD_W-1:0] sel_word,
    input logic [FRAC_W-1:0] acc_phase,
    input logic [DIV_W-1:0]  div_ratio
);
    logic [FRAC_W:0] chk_tot;
    logic [DIV_W-1:0] chk_base;
    assign chk_tot  = {1'b0, acc_phase} + {1'b0, sel_word[FRAC_W-1:0]};
    assign chk_base = DIV_W'(sel_word[WORD_W-1:FRAC_W]) + DIV_W'(OFFSET);

    p_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> (div_ratio == DIV_W'(OFFSET)));

    p_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_tot[FRAC_W] |=> (div_ratio == $past(chk_base) + DIV_W'(1)));

    p_nocarry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_tot[FRAC_W] |=> (div_ratio == $past(chk_base)));

    p_fsk_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsk_mode && tx_bit) |-> (sel_word == up_word));

    p_ask_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fsk_mode |-> (sel_word == lo_word));

    p_phase_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (acc_phase == $past(chk_tot[FRAC_W-1:0])));
endmodule

bind frac_div_ctrl frac_div_ctrl_chk #(
    .WORD_W(WORD_W), .FRAC_W(FRAC_W), .OFFSET(OFFSET), .DIV_W(DIV_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsk_mode  (fsk_mode),
    .tx_bit    (tx_bit),
    .lo_word   (lo_word),
    .up_word   (up_word),
    .sel_word  (sel_word),
    .acc_phase (acc_phase),
    .div_ratio (div_ratio)
);

// File: tb/test_frac_div_ctrl.sv
module test_frac_div_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       fsk_mode = 1'b0;
    logic       tx_bit = 1'b0;
    logic [5:0] div_ratio;

    int total = 0;
    int bad = 0;
    bit run_cmp = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    int m_lo = 0, m_up = 0, m_acc = 0, exp_div = 16;

    always #4 clk = ~clk;

    frac_div_ctrl i_frac_div_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fsk_mode(fsk_mode), .tx_bit(tx_bit),
        .div_ratio(div_ratio)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: old words feed the current addition, writes land after
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 0; m_up = 0; m_acc = 0; exp_div = 16;
        end else begin
            int sel, s;
            sel = (fsk_mode && tx_bit) ? m_up : m_lo;
            s = m_acc + (sel % 4096);
            exp_div = sel / 4096 + 16 + ((s >= 4096) ? 1 : 0);
            m_acc = s % 4096;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_lo = (m_lo % 256) + int'(wr_data) * 256;
                    2'd1: m_lo = (m_lo / 256) * 256 + int'(wr_data);
                    2'd2: m_up = (m_up % 256) + int'(wr_data) * 256;
                    default: m_up = (m_up / 256) * 256 + int'(wr_data);
                endcase
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (run_cmp) check(int'(div_ratio) == exp_div, cur_req, int'(div_ratio), exp_div);
    end

    task automatic wr_byte(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        check(div_ratio == 6'd16, "R1", int'(div_ratio), 16);
        run_cmp = 1'b1;
        idle(2);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check(div_ratio == 6'd16, "R1", int'(div_ratio), 16);
        idle(3);

        // R2/R3/R4: low tone 0x8D81, amplitude mode
        cur_req = "R2";
        wr_byte(0, 8'h8D);
        idle(2);
        wr_byte(1, 8'h81);
        cur_req = "R4";
        idle(300);

        // R9: zero fraction -> constant 21
        cur_req = "R9";
        wr_byte(0, 8'h50);
        wr_byte(1, 8'h00);
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 8192; i++) begin
            @(posedge clk); #1;
            if (i >= 4096 && i < 4116) check(div_ratio == 6'd21, "R9", int'(div_ratio), 21);
        end

        // R5: frequency-shift mode, tone toggling, high tone 0xFE37
        cur_req = "R5";
        wr_byte(0, 8'h8D); wr_byte(1, 8'h81);
        wr_byte(2, 8'hFE); wr_byte(3, 8'h37);
        fsk_mode = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            tx_bit = ((i / 3) % 2 == 1) || (i % 7 == 0);
        end
        @(negedge clk) tx_bit = 1'b1;
        idle(2);
        check(div_ratio >= 6'd31, "R5", int'(div_ratio), 31);

        // R6: amplitude mode ignores data bit
        cur_req = "R6";
        fsk_mode = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            tx_bit = i[0];
            if (i > 2) check(div_ratio <= 6'd25, "R6", int'(div_ratio), 25);
        end

        // R7: writes into the active word while running, tone switch at carry
        cur_req = "R7";
        fsk_mode = 1'b1;
        for (int i = 0; i < 60; i++) begin
            tx_bit = i[1];
            wr_byte(i % 4, (i * 37 + 11) % 256);
            idle(i % 3);
        end

        // R8: average over 4096 outputs for low tone 0x3001
        cur_req = "R8";
        fsk_mode = 1'b0;
        wr_byte(0, 8'h30);
        wr_byte(1, 8'h01);
        begin
            int sum = 0;
            for (int i = 0; i < 4096; i++) begin
                @(posedge clk); #1;
                sum += int'(div_ratio);
            end
            check(sum == 4096 * 19 + 1, "R8", sum, 4096 * 19 + 1);
        end

        // R8 again with a large fraction
        wr_byte(1, 8'hFF);
        wr_byte(0, 8'h2F);
        @(negedge clk);
        begin
            int sum = 0;
            for (int i = 0; i < 4096; i++) begin
                @(posedge clk); #1;
                sum += int'(div_ratio);
            end
            check(sum == 4096 * 18 + 4095, "R8", sum, 4096 * 18 + 4095);
        end

        done = 1'b1;
        run_cmp = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule